// File: doc/BRIEF.md
# Flash Operating-Mode Control Register

This block is the 8-bit, memory-mapped control register that selects how an embedded flash array is being used. The array can be read normally, prepared for programming or erasing, driven through a program or erase action, or read back in a verify mode. Software changes the mode by writing the register. Each bit is guarded by an interlock: a bit can change only when the bits it depends on were already set before that write, and only while an external protection pin is high. Because of this, no action can be reached without first passing through its setup step.

The protection pin passes through a small synchronizer. Its synchronized level appears as a read-only status bit at the top of the register. A low level on the pin, a reset, or either standby request clears every writable bit and returns the array to its protected, read-only state. While the flash is disabled, the register reads as zero and ignores writes. The block decodes the stored bits into a one-hot mode vector for the flash sequencer. It also drives an inhibit line that blocks ordinary array reads while software write enable is set, unless a verify mode is selected.

Top module: `flash_mode_ctl`

## Requirements
- R1: Read bit 7 is the protection pin level delayed by SYNC_STAGES clocks (default 2). With reset held long enough, the register reads 0x80 when the pin is high and 0x00 when it is low.
- R2: An active-low asynchronous reset clears bits 6..0. A high level on either standby input clears bits 6..0 at the next clock edge, and this clear takes priority over a write in the same cycle.
- R3: While flash_en is low, rd_data is 0x00 and a write leaves bits 6..0 unchanged.
- R4: Bit 6, software write enable, takes the written value only while the synchronized pin is high.
- R5: Bits 5 (erase setup), 4 (program setup), 3 (erase verify) and 2 (program verify) take the written value only when the synchronized pin is high and bit 6 was 1 before the write.
- R6: Bit 1 (erase) takes the written value only when the pin is high and bits 6 and 5 were 1 before the write. Bit 0 (program) needs the pin high and bits 6 and 4 set before the write. Writing 0x7F to a cleared register therefore yields 0x40 in bits 6..0.
- R7: Once the synchronized pin is low, bits 6..0 are all zero after the next clock edge.
- R8: mode_onehot always has exactly one bit set. The bits are: [6] program (bits 0, 4 and 6 set), [5] erase (bits 1, 5 and 6 set), [4] program verify (bits 2 and 6), [3] erase verify (bits 3 and 6), [2] program setup (bits 4 and 6), [1] erase setup (bits 5 and 6), [0] normal read. When several apply, the highest listed index wins.
- R9: read_inhibit is 1 exactly when bit 6 is set and mode_onehot is neither [4] nor [3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_standby | input | 1 | Hardware standby request, clears control bits |
| sw_standby | input | 1 | Software standby request, clears control bits |
| flash_en | input | 1 | On-chip flash enabled |
| prot_pin | input | 1 | External write-protection pin, high allows changes |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data (bit 7 ignored) |
| rd_data | output | 8 | Register read value |
| mode_onehot | output | 7 | Decoded operating mode |
| read_inhibit | output | 1 | Blocks ordinary array reads |

## Verification
Assertions check the following on every cycle:
- Each setup, verify or action bit rises only when its prerequisites held in the cycle before.
- A low synchronized pin or a standby request empties the control bits one edge later.
- The mode vector stays one-hot.
- A write made while the flash is disabled changes nothing.

Some behaviour only the bench scenarios can show. These include the exact readback after multi-bit writes, the priority chosen when several modes qualify, and the pin latency seen at the register. They also include a stale action bit left behind after write enable is cleared, which must decode to normal read.

// File: rtl/flash_mode_pkg.sv
package flash_mode_pkg;

   localparam int REG_W   = 8;
   localparam int CTL_W   = 7;
   localparam int N_MODES = 7;

   typedef struct packed {
      logic swe;
      logic esu;
      logic psu;
      logic ev;
      logic pv;
      logic e;
      logic p;
   } ctl_bits_t;

   localparam int M_READ  = 0;
   localparam int M_ESU   = 1;
   localparam int M_PSU   = 2;
   localparam int M_EVFY  = 3;
   localparam int M_PVFY  = 4;
   localparam int M_ERASE = 5;
   localparam int M_PROG  = 6;

endpackage

// File: rtl/fmc_pin_sync.sv
module fmc_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic pin_in,
   output logic pin_sync
);

   generate
      if (STAGES == 0) begin : g_direct
         assign pin_sync = pin_in;
      end else if (STAGES == 1) begin : g_one
         logic q;
         always_ff @(posedge clk) q <= pin_in;
         assign pin_sync = q;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk) q <= {q[STAGES-2:0], pin_in};
         assign pin_sync = q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/fmc_ctl_reg.sv
module fmc_ctl_reg
   import flash_mode_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear_req,
   input  logic                 pin_ok,
   input  logic                 wr_req,
   input  logic [CTL_W-1:0]     wr_bits,
   output ctl_bits_t            st
);

   ctl_bits_t wmask;
   ctl_bits_t st_nxt;

   always_comb begin
      wmask     = '0;
      wmask.swe = pin_ok;
      wmask.esu = pin_ok & st.swe;
      wmask.psu = pin_ok & st.swe;
      wmask.ev  = pin_ok & st.swe;
      wmask.pv  = pin_ok & st.swe;
      wmask.e   = pin_ok & st.swe & st.esu;
      wmask.p   = pin_ok & st.swe & st.psu;
   end

   always_comb begin
      st_nxt = st;
      if (clear_req || !pin_ok)
         st_nxt = '0;
      else if (wr_req)
         st_nxt = (st & ~wmask) | (ctl_bits_t'(wr_bits) & wmask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= '0;
      else        st <= st_nxt;
   end

   assert_standby_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clear_req |=> (st == '0));

   assert_pin_low_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_ok |=> (st == '0));

   assert_swe_needs_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st.swe) |-> $past(pin_ok));

   assert_setup_needs_swe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(st.esu) || $rose(st.psu) || $rose(st.ev) || $rose(st.pv)) |-> $past(st.swe && pin_ok));

   assert_erase_needs_esu_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st.e) |-> $past(st.swe && st.esu));

   assert_prog_needs_psu_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st.p) |-> $past(st.swe && st.psu));

endmodule

// File: rtl/fmc_mode_decode.sv
module fmc_mode_decode
   import flash_mode_pkg::*;
(
   input  ctl_bits_t            st,
   output logic [N_MODES-1:0]   mode_oh,
   output logic                 inhibit
);

   logic act_p, act_e, vfy_p, vfy_e, set_p, set_e;

   assign act_p = st.swe & st.psu & st.p;
   assign act_e = st.swe & st.esu & st.e;
   assign vfy_p = st.swe & st.pv;
   assign vfy_e = st.swe & st.ev;
   assign set_p = st.swe & st.psu;
   assign set_e = st.swe & st.esu;

   always_comb begin
      mode_oh = '0;
      if      (act_p) mode_oh[M_PROG]  = 1'b1;
      else if (act_e) mode_oh[M_ERASE] = 1'b1;
      else if (vfy_p) mode_oh[M_PVFY]  = 1'b1;
      else if (vfy_e) mode_oh[M_EVFY]  = 1'b1;
      else if (set_p) mode_oh[M_PSU]   = 1'b1;
      else if (set_e) mode_oh[M_ESU]   = 1'b1;
      else            mode_oh[M_READ]  = 1'b1;
   end

   assign inhibit = st.swe & ~(mode_oh[M_PVFY] | mode_oh[M_EVFY]);

endmodule

// File: rtl/flash_mode_ctl.sv
module flash_mode_ctl
   import flash_mode_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hw_standby,
   input  logic        sw_standby,
   input  logic        flash_en,
   input  logic        prot_pin,
   input  logic        wr_en,
   input  logic [7:0]  wr_data,
   output logic [7:0]  rd_data,
   output logic [6:0]  mode_onehot,
   output logic        read_inhibit
);

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic      pin_s;
   ctl_bits_t st;
   logic      unused_status_bit;

   assign unused_status_bit = wr_data[REG_W-1];

   fmc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .pin_in   (prot_pin),
      .pin_sync (pin_s)
   );

   fmc_ctl_reg u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_req (hw_standby | sw_standby),
      .pin_ok    (pin_s),
      .wr_req    (wr_en & flash_en),
      .wr_bits   (wr_data[CTL_W-1:0]),
      .st        (st)
   );

   fmc_mode_decode u_dec (
      .st      (st),
      .mode_oh (mode_onehot),
      .inhibit (read_inhibit)
   );

   assign rd_data = flash_en ? {pin_s, st} : '0;

   assert_disabled_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!flash_en && pin_s && !hw_standby && !sw_standby) |=> $stable(st));

   assert_mode_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mode_onehot) == 1);

   assert_action_inhibits_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_onehot[M_PROG] || mode_onehot[M_ERASE]) |-> read_inhibit);

endmodule

// File: tb/flash_mode_ctl_tb.sv
`timescale 1ns/1ps
module flash_mode_ctl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hw_standby = 1'b0, sw_standby = 1'b0;
   logic       flash_en = 1'b1, prot_pin = 1'b1, wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic [6:0] mode_onehot;
   logic       read_inhibit;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   flash_mode_ctl #(.SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .sw_standby(sw_standby),
      .flash_en(flash_en), .prot_pin(prot_pin), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .mode_onehot(mode_onehot), .read_inhibit(read_inhibit));

   // reference model
   logic [1:0] m_pipe;
   logic [6:0] m_st;
   wire        m_pin = m_pipe[1];

   always @(posedge clk) m_pipe <= {m_pipe[0], prot_pin};

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_st <= 7'h00;
      else if (hw_standby || sw_standby || !m_pin) m_st <= 7'h00;
      else if (wr_en && flash_en) begin
         logic [6:0] n;
         n = m_st;
         n[6] = wr_data[6];
         if (m_st[6]) begin
            n[5] = wr_data[5]; n[4] = wr_data[4];
            n[3] = wr_data[3]; n[2] = wr_data[2];
            if (m_st[5]) n[1] = wr_data[1];
            if (m_st[4]) n[0] = wr_data[0];
         end
         m_st <= n;
      end
   end

   function automatic logic [6:0] exp_mode(input logic [6:0] s);
      if (!s[6])               return 7'h01;
      if (s[0] && s[4])        return 7'h40;
      if (s[1] && s[5])        return 7'h20;
      if (s[2])                return 7'h10;
      if (s[3])                return 7'h08;
      if (s[4])                return 7'h04;
      if (s[5])                return 7'h02;
      return 7'h01;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // per-cycle comparison against the model
   always @(posedge clk) begin
      cyc++;
      #1;
      if (cyc > 4) begin
         logic [7:0] er;
         logic [6:0] em;
         er = flash_en ? {m_pin, m_st} : 8'h00;
         em = exp_mode(m_st);
         check(rd_data == er, "R6 readback", rd_data, er);
         check(mode_onehot == em, "R8 mode", mode_onehot, em);
         check(read_inhibit == (m_st[6] && em != 7'h10 && em != 7'h08), "R9 inhibit",
               read_inhibit, (m_st[6] && em != 7'h10 && em != 7'h08));
      end
   end

   task automatic wr(input logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      // R1: reset with pin high, then with pin low
      idle(8);
      check(rd_data == 8'h80, "R1 reset pin high", rd_data, 8'h80);
      prot_pin = 1'b0; idle(4);
      check(rd_data == 8'h00, "R1 reset pin low", rd_data, 8'h00);
      prot_pin = 1'b1; idle(4);
      rst_n = 1'b1; idle(2);

      // R4/R6: one write cannot set a prerequisite and its dependent
      wr(8'h7F);
      check(rd_data == 8'hC0, "R6 single write", rd_data, 8'hC0);
      // R5: setup bits now writable
      wr(8'h70);
      check(rd_data == 8'hF0, "R5 setup bits", rd_data, 8'hF0);
      wr(8'h73);
      check(rd_data == 8'hF3, "R6 action bits", rd_data, 8'hF3);
      check(mode_onehot == 7'h40, "R8 program priority", mode_onehot, 7'h40);
      check(read_inhibit == 1'b1, "R9 inhibit in program", read_inhibit, 1);
      wr(8'h4C);
      check(rd_data == 8'hCC, "R5 verify bits", rd_data, 8'hCC);
      check(mode_onehot == 7'h10, "R8 pverify over everify", mode_onehot, 7'h10);
      check(read_inhibit == 1'b0, "R9 verify allows reads", read_inhibit, 0);

      // R3: disabled flash
      flash_en = 1'b0; idle(1);
      check(rd_data == 8'h00, "R3 disabled read", rd_data, 8'h00);
      wr(8'h00);
      flash_en = 1'b1; idle(1);
      check(rd_data == 8'hCC, "R3 disabled write ignored", rd_data, 8'hCC);

      // stale action bit after clearing write enable
      wr(8'h60); wr(8'h62); wr(8'h22);
      check(rd_data == 8'hA2, "R4 swe cleared", rd_data, 8'hA2);
      check(mode_onehot == 7'h01, "R8 stale erase bit reads normal", mode_onehot, 7'h01);

      // R7: pin low clears; R4: swe locked while low
      wr(8'h70);
      prot_pin = 1'b0; idle(4);
      check(rd_data == 8'h00, "R7 pin low clears", rd_data, 8'h00);
      wr(8'h40);
      check(rd_data == 8'h00, "R4 swe locked", rd_data, 8'h00);
      prot_pin = 1'b1; idle(3);
      check(rd_data == 8'h80, "R1 pin returns", rd_data, 8'h80);

      // R2: standby clears and beats a write
      wr(8'h40); wr(8'h60);
      hw_standby = 1'b1; wr(8'h70); hw_standby = 1'b0;
      check(rd_data == 8'h80, "R2 hw standby", rd_data, 8'h80);
      wr(8'h40);
      sw_standby = 1'b1; idle(1); sw_standby = 1'b0;
      check(rd_data == 8'h80, "R2 sw standby", rd_data, 8'h80);
      wr(8'h40); wr(8'h50);
      rst_n = 1'b0; #1;
      check(rd_data == 8'h80, "R2 async reset", rd_data, 8'h80);
      idle(1); rst_n = 1'b1; idle(1);

      // mixed traffic compared against the model every cycle
      for (int i = 0; i < 600; i++) begin
         wr_en      = ($urandom % 2) == 0;
         wr_data    = 8'($urandom);
         if (($urandom % 40) == 0) prot_pin = ~prot_pin;
         if (!prot_pin && ($urandom % 4) == 0) prot_pin = 1'b1;
         flash_en   = ($urandom % 10) != 0;
         hw_standby = ($urandom % 50) == 0;
         sw_standby = ($urandom % 50) == 0;
         @(negedge clk);
      end
      wr_en = 1'b0; hw_standby = 1'b0; sw_standby = 1'b0;
      idle(2);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule